// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is one logic cell of a programmable array. It takes a single fast product term and a wide OR sum. A small function stage combines the two through a four-entry truth table. The result either goes straight to the output or into a storage element. The storage element can act as an edge-triggered data register, an edge-triggered toggle register or a level-sensitive latch.

Static configuration inputs choose the following:
- the truth table;
- the output mode;
- the clock source, which is the global clock or one of the local control terms;
- an optional inversion of that clock;
- the value loaded at power-on.

The cell has a clock enable and asynchronous clear, set and power-on load. The clock enable applies to both edge modes.

Top module: `mc_macrocell`

## Requirements
- R1: With `cfg_mode` = 0 (combinational), `q` equals bit `2*pt_fast + or_sum` of `cfg_tt` at all times, with no clock.
- R2: With `cfg_mode` = 1 (data register), `q` takes the function value on each active edge of the selected clock while `ce` is high.
- R3: With `ce` low, an active edge leaves `q` unchanged in both data and toggle modes.
- R4: With `cfg_mode` = 2 (toggle register), an active edge inverts `q` when `ce` and the function value are both high, and otherwise leaves `q` unchanged.
- R5: With `cfg_mode` = 3 (latch), `q` follows the function value while the selected clock is at its active level and holds it while the clock is inactive; `ce` has no effect.
- R6: `arst` high forces `q` to 0 at once, without a clock edge, and wins over `apre` and over any clock edge.
- R7: `apre` high with `arst` low forces `q` to 1 at once, without a clock edge.
- R8: `por` high loads `cfg_init` into the storage element at once and takes precedence over `arst` and `apre`.
- R9: `cfg_clk_src` = 0 selects `gclk` and a value k from 1 to `NUM_LCT` selects `lct[k-1]`. Any larger value selects a constant with no edges. Edges on unselected sources have no effect.
- R10: With `cfg_clk_inv` = 1, the falling edge of the selected source is the active edge, and in latch mode the latch is transparent while the source is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock, clock source 0 |
| lct | input | NUM_LCT | Local control terms usable as clock or latch enable |
| pt_fast | input | 1 | Fast single product term |
| or_sum | input | 1 | Wide OR sum term |
| ce | input | 1 | Clock enable for the data and toggle modes |
| arst | input | 1 | Asynchronous clear, active high |
| apre | input | 1 | Asynchronous set, active high |
| por | input | 1 | Power-on load of `cfg_init`, active high |
| cfg_tt | input | 4 | Truth table of the two-input function |
| cfg_mode | input | 2 | 0 combinational, 1 data, 2 toggle, 3 latch |
| cfg_clk_src | input | SRC_W | Clock source index |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_init | input | 1 | Power-on value |
| q | output | 1 | Macrocell output |

## Verification
The hardest cases to reach are those where an edge should have no effect: a pulse on an unselected control term, or a rising edge when the clock is inverted. Either one can change the register only if the state is first moved to a value the edge would overwrite. The stimulus therefore loads a known value with a power-on pulse before each such case. It then chooses a function value opposite to the stored one and pulses every other source, or only the inactive half of a pulse. The output is checked between these steps. Configuration changes can themselves create clock edges, so every configuration change is followed by a power-on load.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
   typedef enum logic [1:0] {
      MODE_COMB  = 2'd0,
      MODE_D     = 2'd1,
      MODE_T     = 2'd2,
      MODE_LATCH = 2'd3
   } mc_mode_e;

   localparam int FN_INPUTS = 2;
   localparam int TT_W      = 1 << FN_INPUTS;
endpackage

// File: rtl/mc_vfm.sv
`timescale 1ns/1ps
// Two-input function stage: the truth table is indexed by {a, b}.
module mc_vfm
   import mc_pkg::*;
(
   input  logic            a_i,
   input  logic            b_i,
   input  logic [TT_W-1:0] tt_i,
   output logic            f_o
);
   logic [FN_INPUTS-1:0] idx;
   assign idx = {a_i, b_i};
   assign f_o = tt_i[idx];
endmodule

// File: rtl/mc_clk_sel.sv
`timescale 1ns/1ps
// Clock source selector: index 0 is the global clock, 1..NUM_LCT the local terms.
module mc_clk_sel #(
   parameter int NUM_LCT = 8,
   localparam int NSRC  = NUM_LCT + 1,
   localparam int SRC_W = $clog2(NSRC),
   localparam int PAD   = 1 << SRC_W
) (
   input  logic               gclk,
   input  logic [NUM_LCT-1:0] lct,
   input  logic [SRC_W-1:0]   sel_i,
   input  logic               inv_i,
   output logic               clk_o
);
   logic [PAD-1:0] pool;

   generate
      for (genvar i = 0; i < PAD; i++) begin : g_pool
         if (i == 0) begin : g_glob
            assign pool[i] = gclk;
         end else if (i <= NUM_LCT) begin : g_lct
            assign pool[i] = lct[i-1];
         end else begin : g_tie
            assign pool[i] = 1'b0;
         end
      end
   endgenerate

   assign clk_o = pool[sel_i] ^ inv_i;

   // R9: an index beyond the last term never produces edges
   a_r9_unused_src_quiet : assert property (@(posedge gclk)
      (int'(sel_i) > NUM_LCT) |-> (clk_o == inv_i));
endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
// Storage element: edge register (data or toggle) plus optional latch.
module mc_store
   import mc_pkg::*;
#(
   parameter bit LATCH_EN = 1'b1
) (
   input  logic     clk,
   input  logic     chk_clk,
   input  logic     por,
   input  logic     arst,
   input  logic     apre,
   input  logic     init_i,
   input  mc_mode_e mode_i,
   input  logic     ce_i,
   input  logic     d_i,
   output logic     q_o
);
   logic q_ff;
   logic q_lat;
   logic ff_next;

   always_comb begin
      ff_next = q_ff;
      if (ce_i) begin
         if (mode_i == MODE_T) ff_next = q_ff ^ d_i;
         else                  ff_next = d_i;
      end
   end

   always_ff @(posedge clk or posedge por or posedge arst or posedge apre) begin
      if (por)       q_ff <= init_i;
      else if (arst) q_ff <= 1'b0;
      else if (apre) q_ff <= 1'b1;
      else           q_ff <= ff_next;
   end

   generate
      if (LATCH_EN) begin : g_latch
         always_latch begin
            if (por)                               q_lat <= init_i;
            else if (arst)                         q_lat <= 1'b0;
            else if (apre)                         q_lat <= 1'b1;
            else if (clk && mode_i == MODE_LATCH)  q_lat <= d_i;
         end

         // R5: transparent while the enable is active
         a_r5_latch_follows : assert property (@(posedge chk_clk)
            disable iff (por || arst || apre)
            (mode_i == MODE_LATCH && clk) |-> (q_o == d_i));
      end else begin : g_nolatch
         assign q_lat = q_ff;
      end
   endgenerate

   assign q_o = (mode_i == MODE_LATCH) ? q_lat : q_ff;

   // R6: clear dominates set
   a_r6_clear_wins : assert property (@(posedge chk_clk)
      disable iff (por) arst |-> (q_o == 1'b0));
   // R7: set alone forces one
   a_r7_set_alone : assert property (@(posedge chk_clk)
      disable iff (por) (apre && !arst) |-> (q_o == 1'b1));
   // R8: power-on load
   a_r8_por_loads : assert property (@(posedge chk_clk)
      por |-> (q_o == init_i));
endmodule

// File: rtl/mc_macrocell.sv
`timescale 1ns/1ps
module mc_macrocell
   import mc_pkg::*;
#(
   parameter int NUM_LCT  = 8,
   parameter bit LATCH_EN = 1'b1,
   localparam int SRC_W   = $clog2(NUM_LCT + 1)
) (
   input  logic               gclk,
   input  logic [NUM_LCT-1:0] lct,
   input  logic               pt_fast,
   input  logic               or_sum,
   input  logic               ce,
   input  logic               arst,
   input  logic               apre,
   input  logic               por,
   input  logic [3:0]         cfg_tt,
   input  logic [1:0]         cfg_mode,
   input  logic [SRC_W-1:0]   cfg_clk_src,
   input  logic               cfg_clk_inv,
   input  logic               cfg_init,
   output logic               q
);
   generate
      if (NUM_LCT < 1 || NUM_LCT > 64) begin : g_bad_lct
         $error("mc_macrocell: NUM_LCT must lie in 1..64");
      end
      if (TT_W != 4) begin : g_bad_tt
         $error("mc_macrocell: function stage must have four table entries");
      end
   endgenerate

   mc_mode_e mode;
   logic     fn_val;
   logic     sel_clk;
   logic     stored;

   assign mode = mc_mode_e'(cfg_mode);

   mc_vfm u_vfm (
      .a_i  (pt_fast),
      .b_i  (or_sum),
      .tt_i (cfg_tt),
      .f_o  (fn_val)
   );

   mc_clk_sel #(.NUM_LCT(NUM_LCT)) u_clk_sel (
      .gclk  (gclk),
      .lct   (lct),
      .sel_i (cfg_clk_src),
      .inv_i (cfg_clk_inv),
      .clk_o (sel_clk)
   );

   mc_store #(.LATCH_EN(LATCH_EN)) u_store (
      .clk     (sel_clk),
      .chk_clk (gclk),
      .por     (por),
      .arst    (arst),
      .apre    (apre),
      .init_i  (cfg_init),
      .mode_i  (mode),
      .ce_i    (ce),
      .d_i     (fn_val),
      .q_o     (stored)
   );

   assign q = (mode == MODE_COMB) ? fn_val : stored;

   // R1: combinational mode shows the table entry picked by the inputs
   a_r1_comb_table : assert property (@(posedge gclk)
      (cfg_mode == 2'd0) |-> (q == cfg_tt[{pt_fast, or_sum}]));
endmodule

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;
   localparam int NL    = 8;
   localparam int SRC_W = $clog2(NL + 1);

   logic             gclk = 1'b0;
   logic [NL-1:0]    lct = '0;
   logic             pt_fast = 0, or_sum = 0, ce = 0, arst = 0, apre = 0, por = 0;
   logic [3:0]       cfg_tt = 4'h0;
   logic [1:0]       cfg_mode = 2'd0;
   logic [SRC_W-1:0] cfg_clk_src = '0;
   logic             cfg_clk_inv = 0, cfg_init = 0;
   logic             q;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 gclk = ~gclk;

   mc_macrocell #(.NUM_LCT(NL)) dut (
      .gclk(gclk), .lct(lct), .pt_fast(pt_fast), .or_sum(or_sum), .ce(ce),
      .arst(arst), .apre(apre), .por(por), .cfg_tt(cfg_tt), .cfg_mode(cfg_mode),
      .cfg_clk_src(cfg_clk_src), .cfg_clk_inv(cfg_clk_inv), .cfg_init(cfg_init), .q(q)
   );

   task automatic chk(input string req, input logic exp);
      checks++;
      if (q !== exp) begin
         errors++;
         $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
      end
   endtask

   task automatic win();
      @(negedge gclk); #0.2;
   endtask

   task automatic do_por(input logic iv);
      win(); cfg_init = iv; #0.2 por = 1; #0.3 por = 0; #0.2;
   endtask

   task automatic setup(input logic [1:0] m, input logic [3:0] tt,
                        input int src, input logic inv, input logic iv);
      win(); cfg_mode = m; cfg_tt = tt; cfg_clk_src = SRC_W'(src); cfg_clk_inv = inv;
      do_por(iv);
   endtask

   task automatic pulse(input int src);
      win();
      if (src >= 1 && src <= NL) lct[src-1] = 1;
      #0.3;
      if (src >= 1 && src <= NL) lct[src-1] = 0;
      #0.3;
   endtask

   function automatic logic tbit(input logic [3:0] tt, input int p, input int s);
      return tt[2*p + s];
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic exp;
      // R8 reset state via power-on load, both values
      setup(2'd1, 4'h0, 1, 0, 1'b1); chk("R8 por init=1", 1'b1);
      do_por(1'b0);                  chk("R8 por init=0", 1'b0);

      // R1 combinational sweep over all tables and inputs
      win(); cfg_mode = 2'd0;
      for (int t = 0; t < 16; t++)
         for (int i = 0; i < 4; i++) begin
            win(); cfg_tt = 4'(t); pt_fast = i[1]; or_sum = i[0]; #0.3;
            chk("R1 comb", tbit(4'(t), i / 2, i % 2));
         end

      // R2 data register sweep
      setup(2'd1, 4'h0, 1, 0, 1'b0);
      win(); ce = 1;
      for (int t = 0; t < 16; t++)
         for (int i = 0; i < 4; i++) begin
            win(); cfg_tt = 4'(t); pt_fast = i[1]; or_sum = i[0];
            pulse(1);
            chk("R2 data load", tbit(4'(t), i / 2, i % 2));
         end

      // R3 enable low holds in data mode
      setup(2'd1, 4'hF, 1, 0, 1'b0);
      win(); ce = 0; pulse(1); chk("R3 data hold", 1'b0);
      win(); ce = 1; pulse(1); chk("R2 data after hold", 1'b1);

      // R4 toggle mode (f = or_sum with table 4'hA), R3 for enable low
      setup(2'd2, 4'hA, 1, 0, 1'b0);
      exp = 0;
      for (int i = 0; i < 16; i++) begin
         win(); ce = i[0] ^ i[2]; or_sum = i[1]; pt_fast = i[3];
         pulse(1);
         if (ce && or_sum) exp = ~exp;
         chk(ce ? "R4 toggle" : "R3 toggle hold", exp);
      end

      // R5 latch mode, enable = lct[1], f = pt_fast with table 4'hC
      setup(2'd3, 4'hC, 2, 0, 1'b0);
      win(); ce = 0; lct[1] = 1;
      for (int i = 0; i < 4; i++) begin
         win(); pt_fast = i[0]; #0.3; chk("R5 latch transparent", i[0]);
      end
      win(); pt_fast = 1; #0.2 lct[1] = 0; #0.2 pt_fast = 0; #0.3;
      chk("R5 latch holds", 1'b1);
      win(); pt_fast = 1; #0.2 pt_fast = 0; #0.3; chk("R5 latch holds after toggle", 1'b1);

      // R10 inverted latch enable: transparent while source low
      setup(2'd3, 4'hC, 2, 1, 1'b0);
      win(); pt_fast = 1; #0.3; chk("R10 inverted latch open", 1'b1);
      win(); lct[1] = 1; #0.2 pt_fast = 0; #0.3; chk("R10 inverted latch closed", 1'b1);
      win(); lct[1] = 0; #0.3; chk("R10 inverted latch reopens", 1'b0);

      // R6 / R7 asynchronous controls in data mode
      setup(2'd1, 4'hF, 1, 0, 1'b0);
      win(); ce = 1; apre = 1; #0.3; chk("R7 set", 1'b1);
      win(); arst = 1; #0.3; chk("R6 clear over set", 1'b0);
      win(); arst = 0; apre = 0; #0.3;
      win(); arst = 1; #0.3; apre = 1; #0.3; chk("R6 clear holds vs later set", 1'b0);
      win(); arst = 0; apre = 0;
      win(); arst = 1; #0.1; pulse(1); chk("R6 clear beats clock", 1'b0);
      win(); arst = 0; #0.3;
      // R8 power-on beats set
      win(); apre = 1; #0.2; cfg_init = 0; por = 1; #0.3; chk("R8 por over set", 1'b0);
      apre = 0; #0.2; por = 0; #0.2;

      // R9 source selection: only the chosen term clocks
      for (int s = 1; s <= NL; s++) begin
         setup(2'd1, 4'hF, s, 0, 1'b0);
         win(); ce = 1;
         for (int k = 1; k <= NL; k++) if (k != s) pulse(k);
         chk("R9 other sources ignored", 1'b0);
         pulse(s);
         chk("R9 chosen source clocks", 1'b1);
      end
      setup(2'd1, 4'hF, 12, 0, 1'b0);
      for (int k = 1; k <= NL; k++) pulse(k);
      chk("R9 out-of-range source quiet", 1'b0);

      // R10 inverted edge: falling edge is active
      setup(2'd1, 4'hF, 3, 1, 1'b0);
      win(); lct[2] = 1; #0.3; chk("R10 rising edge inactive", 1'b0);
      win(); lct[2] = 0; #0.3; chk("R10 falling edge active", 1'b1);

      // R9 global clock source
      setup(2'd1, 4'hF, 5, 0, 1'b0);
      win(); cfg_clk_src = '0; #0.2 cfg_init = 0; por = 1; #0.3 por = 0; #0.2;
      chk("R9 global before edge", 1'b0);
      @(posedge gclk); #0.5; chk("R9 global edge loads", 1'b1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule